// File: doc/BRIEF.md
# Debug Run-Control Unit

This block gives a host control over when a small embedded packet-processing core runs. The host uses a small register interface. A command register takes one-shot requests to restart, stop, single-step and raise break-out. An option register selects how debug events are handled. A plain control register takes a run/stop value. A status word reports why the core halted, together with the core's current program counter. The block drives one run enable to the core.

Two event inputs come from outside the block. The first is an external break-in request. The second is a one-cycle hit indication from breakpoint comparators that sit elsewhere. The option register routes each event on its own: it can halt the core, it can produce a one-cycle break-out pulse for other debug agents, or both. Each option field uses a write-enable bit. This lets the host change one option without first reading the others.

Top module: `dbg_run_ctrl`

## Requirements
- R1: After reset the run enable is high, every option reads as 0, status bits [2:0] read as 0 and break_out_o is low.
- R2: Option register address 1 holds four 2-bit fields: [1:0] break-out on stop, [3:2] break-out on break-in, [5:4] halt on break-in, [7:6] halt on breakpoint. Writing 2'b11 to a field sets the option and 2'b10 clears it. Writing 2'b00 or 2'b01 leaves it unchanged. A read returns each option in bit 0, 2, 4 or 6, and every other bit reads as 0.
- R3: A stop request lowers core_run_o from the next cycle and sets status bit 0. A stop request is either command bit 1 (command address 0) or the value 1 written to control address 2.
- R4: A restart request clears status bits [2:0] and raises core_run_o from the next cycle. A restart request is either command bit 0 or the value 0 written to control address 2. When stop and restart arrive in the same command write, stop wins.
- R5: A break-in while halt-on-break-in is set lowers core_run_o and sets status bit 1. While that option is clear, a break-in changes neither the run enable nor status bit 1.
- R6: A breakpoint hit while halt-on-breakpoint is set lowers core_run_o and sets status bit 2. While that option is clear, a hit changes neither the run enable nor status bit 2.
- R7: Command bit 2 (step) while halted raises core_run_o from the next cycle. It stays high until core_retire_i is seen, and it is low from the cycle after that. A step while running has no effect.
- R8: break_out_o is high for the one cycle after any of these: command bit 3; a halt event that takes the core out of running or stepping while break-out on stop is set; a break-in while break-out on break-in is set.
- R9: Status address 3 returns core_pc_i, zero-extended, in bits [31:16] in the same cycle. Bits [15:3] read as 0.
- R10: Writes to status address 3 are ignored. Control-address values other than 0 and 1 are ignored. Command and control addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 command, 1 option, 2 control, 3 status) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| break_in_i | input | 1 | External break-in request |
| bkpt_hit_i | input | 1 | One-cycle breakpoint hit |
| core_retire_i | input | 1 | Core finished one instruction |
| core_pc_i | input | PC_W | Core program counter |
| core_run_o | output | 1 | Run enable to the core |
| break_out_o | output | 1 | One-cycle break-out pulse |

## Verification
The bench builds the block with its default parameters. These are a 32-bit data word, 2-bit address, 16-bit program counter and reset into the running state. With a full 16-bit program counter, every status bit above bit 15 is driven, so the whole upper half-word is compared on each status read. Starting from the running state puts the break-out-on-stop path within reach in the first cycles. It also lets the bench check that a step is ignored while running, before any halt has occurred.

// File: rtl/dbg_rc_pkg.sv
`timescale 1ns/1ps
package dbg_rc_pkg;
   typedef enum logic [1:0] {
      RC_RUN  = 2'd0,
      RC_HALT = 2'd1,
      RC_STEP = 2'd2
   } rc_state_e;

   localparam int N_OPT          = 4;
   localparam int OPT_BO_STOP    = 0;
   localparam int OPT_BO_BRKIN   = 1;
   localparam int OPT_HALT_BRKIN = 2;
   localparam int OPT_HALT_BKPT  = 3;
   localparam int N_REASON       = 3;
   localparam int PC_LSB         = 16;

   localparam int A_CMD  = 0;
   localparam int A_OPT  = 1;
   localparam int A_CTRL = 2;
   localparam int A_STAT = 3;

   typedef struct packed {
      logic restart;
      logic stop;
      logic step;
      logic brkout;
   } rc_cmd_t;
endpackage

// File: rtl/dbg_rc_regs.sv
`timescale 1ns/1ps
module dbg_rc_regs
   import dbg_rc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2,
   parameter int PC_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   input  logic [PC_W-1:0]     pc,
   input  logic [N_REASON-1:0] reasons,
   output rc_cmd_t             cmd,
   output logic [N_OPT-1:0]    opt
);
   logic cmd_wr, opt_wr, ctrl_wr;
   logic [DATA_W-1:0] opt_rd, stat_rd;

   assign cmd_wr  = wr_en && (addr == ADDR_W'(A_CMD));
   assign opt_wr  = wr_en && (addr == ADDR_W'(A_OPT));
   assign ctrl_wr = wr_en && (addr == ADDR_W'(A_CTRL));

   always_comb begin
      cmd.restart = (cmd_wr && wdata[0]) || (ctrl_wr && (wdata == DATA_W'(0)));
      cmd.stop    = (cmd_wr && wdata[1]) || (ctrl_wr && (wdata == DATA_W'(1)));
      cmd.step    = cmd_wr && wdata[2];
      cmd.brkout  = cmd_wr && wdata[3];
   end

   for (genvar k = 0; k < N_OPT; k++) begin : g_opt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       opt[k] <= 1'b0;
         else if (opt_wr && wdata[2*k+1])  opt[k] <= wdata[2*k];
      end
      assign opt_rd[2*k]   = opt[k];
      assign opt_rd[2*k+1] = 1'b0;
   end
   assign opt_rd[DATA_W-1:2*N_OPT] = '0;

   assign stat_rd = (DATA_W'(pc) << PC_LSB) | DATA_W'(reasons);

   always_comb begin
      if (addr == ADDR_W'(A_OPT))       rdata = opt_rd;
      else if (addr == ADDR_W'(A_STAT)) rdata = stat_rd;
      else                              rdata = '0;
   end

   p_opt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !opt_wr |=> $stable(opt));
   p_opt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (opt_wr && wdata[1:0] == 2'b11) |=> opt[0]);
endmodule

// File: rtl/dbg_rc_fsm.sv
`timescale 1ns/1ps
module dbg_rc_fsm
   import dbg_rc_pkg::*;
#(
   parameter bit START_HALTED = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  rc_cmd_t             cmd,
   input  logic [N_OPT-1:0]    opt,
   input  logic                break_in_i,
   input  logic                bkpt_hit_i,
   input  logic                retire_i,
   output rc_state_e           state_q,
   output logic [N_REASON-1:0] reasons_q,
   output logic                enter_halt
);
   localparam rc_state_e RST_ST = START_HALTED ? RC_HALT : RC_RUN;

   logic brkin_halt, bkpt_halt, halt_evt;
   rc_state_e state_d;
   logic [N_REASON-1:0] reasons_d;

   assign brkin_halt = break_in_i && opt[OPT_HALT_BRKIN];
   assign bkpt_halt  = bkpt_hit_i && opt[OPT_HALT_BKPT];
   assign halt_evt   = cmd.stop || brkin_halt || bkpt_halt;
   assign enter_halt = halt_evt && (state_q != RC_HALT);

   always_comb begin
      state_d   = state_q;
      reasons_d = reasons_q;
      if (halt_evt) begin
         state_d   = RC_HALT;
         reasons_d = reasons_q | {bkpt_halt, brkin_halt, cmd.stop};
      end else if (cmd.restart) begin
         state_d   = RC_RUN;
         reasons_d = '0;
      end else if (cmd.step && state_q == RC_HALT) begin
         state_d   = RC_STEP;
      end else if (state_q == RC_STEP && retire_i) begin
         state_d   = RC_HALT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RST_ST;
         reasons_q <= '0;
      end else begin
         state_q   <= state_d;
         reasons_q <= reasons_d;
      end
   end

   p_stop_halts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.stop |=> (state_q == RC_HALT && reasons_q[0]));
   p_restart_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.restart && !cmd.stop && !break_in_i && !bkpt_hit_i)
      |=> (state_q == RC_RUN && reasons_q == '0));
   p_brkin_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (break_in_i && opt[OPT_HALT_BRKIN]) |=> (state_q == RC_HALT && reasons_q[1]));
   p_bkpt_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bkpt_hit_i && opt[OPT_HALT_BKPT]) |=> (state_q == RC_HALT && reasons_q[2]));
   p_step_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RC_STEP && retire_i && !cmd.restart) |=> state_q == RC_HALT);
   p_step_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RC_RUN && !halt_evt) |=> state_q == RC_RUN);
endmodule

// File: rtl/dbg_rc_brkout.sv
`timescale 1ns/1ps
module dbg_rc_brkout
   import dbg_rc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  rc_cmd_t          cmd,
   input  logic [N_OPT-1:0] opt,
   input  logic             enter_halt,
   input  logic             break_in_i,
   output logic             break_out_o
);
   logic fire;
   assign fire = cmd.brkout
              || (enter_halt && opt[OPT_BO_STOP])
              || (break_in_i && opt[OPT_BO_BRKIN]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) break_out_o <= 1'b0;
      else        break_out_o <= fire;
   end

   p_cmd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.brkout |=> break_out_o);
   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.brkout && !enter_halt && !break_in_i) |=> !break_out_o);
endmodule

// File: rtl/dbg_run_ctrl.sv
`timescale 1ns/1ps
module dbg_run_ctrl
   import dbg_rc_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 2,
   parameter int PC_W         = 16,
   parameter bit START_HALTED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              break_in_i,
   input  logic              bkpt_hit_i,
   input  logic              core_retire_i,
   input  logic [PC_W-1:0]   core_pc_i,
   output logic              core_run_o,
   output logic              break_out_o
);
   if (DATA_W != 32) begin : g_bad_data
      $error("dbg_run_ctrl: DATA_W must be 32");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("dbg_run_ctrl: ADDR_W must be at least 2");
   end
   if (PC_W < 1 || PC_W > 16) begin : g_bad_pc
      $error("dbg_run_ctrl: PC_W must be 1..16");
   end

   rc_cmd_t             cmd;
   logic [N_OPT-1:0]    opt;
   rc_state_e           state;
   logic [N_REASON-1:0] reasons;
   logic                enter_halt;

   dbg_rc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_W(PC_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .pc(core_pc_i),
      .reasons(reasons), .cmd(cmd), .opt(opt)
   );

   dbg_rc_fsm #(.START_HALTED(START_HALTED)) u_fsm (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .opt(opt),
      .break_in_i(break_in_i), .bkpt_hit_i(bkpt_hit_i),
      .retire_i(core_retire_i), .state_q(state), .reasons_q(reasons),
      .enter_halt(enter_halt)
   );

   dbg_rc_brkout u_bo (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .opt(opt),
      .enter_halt(enter_halt), .break_in_i(break_in_i),
      .break_out_o(break_out_o)
   );

   assign core_run_o = (state != RC_HALT);

   p_run_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr_en && !break_in_i && !bkpt_hit_i && !core_retire_i) |=> $stable(core_run_o));
endmodule

// File: tb/dbg_run_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_run_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        bi = 1'b0, bp = 1'b0, rt = 1'b0;
   logic [15:0] pc = '0;
   logic        run, bo;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // model state: 0 run, 1 halt, 2 step
   int         m_st;
   logic [3:0] m_opt;
   logic [2:0] m_rsn;
   logic       m_bo;

   always #2.5 clk = ~clk;

   dbg_run_ctrl u_dbg_run_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(we), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .break_in_i(bi),
      .bkpt_hit_i(bp), .core_retire_i(rt), .core_pc_i(pc),
      .core_run_o(run), .break_out_o(bo)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [1:0] a);
      logic [31:0] r = '0;
      if (a == 2'd1) r = {24'd0, 1'b0, m_opt[3], 1'b0, m_opt[2], 1'b0, m_opt[1], 1'b0, m_opt[0]};
      else if (a == 2'd3) r = {pc, 13'd0, m_rsn};
      return r;
   endfunction

   // one cycle: drive at negedge, check read, advance model, check outputs
   task automatic cyc(input bit w, input logic [1:0] a, input logic [31:0] d,
                      input bit b_i, input bit b_p, input bit r_t,
                      input logic [15:0] p, input string tag);
      bit rs, sp, st, bk, hb, hp, hev;
      int n_st;
      logic [2:0] n_rsn;
      logic [3:0] n_opt;
      logic n_bo;
      we = w; addr = a; wdata = d; bi = b_i; bp = b_p; rt = r_t; pc = p;
      #1;
      check(rdata == exp_rd(a), (a == 2'd1) ? "R2 read" : "R9 read", rdata, exp_rd(a));
      rs = (w && a == 2'd0 && d[0]) || (w && a == 2'd2 && d == 32'd0);
      sp = (w && a == 2'd0 && d[1]) || (w && a == 2'd2 && d == 32'd1);
      st = w && a == 2'd0 && d[2];
      bk = w && a == 2'd0 && d[3];
      hb = b_i && m_opt[2];
      hp = b_p && m_opt[3];
      hev = sp || hb || hp;
      n_st = m_st; n_rsn = m_rsn; n_opt = m_opt;
      if (hev) begin n_st = 1; n_rsn = m_rsn | {hp, hb, sp}; end
      else if (rs) begin n_st = 0; n_rsn = 3'd0; end
      else if (st && m_st == 1) n_st = 2;
      else if (m_st == 2 && r_t) n_st = 1;
      n_bo = bk || (hev && m_st != 1 && m_opt[0]) || (b_i && m_opt[1]);
      if (w && a == 2'd1)
         for (int k = 0; k < 4; k++) if (d[2*k+1]) n_opt[k] = d[2*k];
      @(posedge clk);
      @(negedge clk);
      m_st = n_st; m_rsn = n_rsn; m_opt = n_opt; m_bo = n_bo;
      check(run == (m_st != 1), tag, {31'd0, run}, {31'd0, m_st != 1});
      check(bo == m_bo, "R8 break_out", {31'd0, bo}, {31'd0, m_bo});
   endtask

   task automatic idle(input logic [1:0] a, input string tag);
      cyc(1'b0, a, 32'd0, 1'b0, 1'b0, 1'b0, pc, tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      m_st = 0; m_opt = 4'd0; m_rsn = 3'd0; m_bo = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check(run == 1'b1, "R1 run after reset", {31'd0, run}, 32'd1);
      check(bo == 1'b0, "R1 break_out after reset", {31'd0, bo}, 32'd0);
      idle(2'd1, "R1");
      idle(2'd3, "R1");
      // R2 option encoding
      cyc(1'b1, 2'd1, 32'hFF, 0, 0, 0, pc, "R2");
      idle(2'd1, "R2");
      cyc(1'b1, 2'd1, 32'h55, 0, 0, 0, pc, "R2");
      idle(2'd1, "R2");
      cyc(1'b1, 2'd1, 32'hA0, 0, 0, 0, pc, "R2");
      idle(2'd1, "R2");
      // R3 stop with break-out on stop; R8
      cyc(1'b1, 2'd0, 32'h2, 0, 0, 0, pc, "R3");
      idle(2'd3, "R3");
      cyc(1'b1, 2'd0, 32'h2, 0, 0, 0, pc, "R8 no pulse when already halted");
      // R4 restart and priority
      cyc(1'b1, 2'd0, 32'h1, 0, 0, 0, pc, "R4");
      idle(2'd3, "R4");
      cyc(1'b1, 2'd0, 32'h3, 0, 0, 0, pc, "R4 stop wins");
      cyc(1'b1, 2'd2, 32'h0, 0, 0, 0, pc, "R4 ctrl restart");
      cyc(1'b1, 2'd2, 32'h5, 0, 0, 0, pc, "R10 ctrl value ignored");
      cyc(1'b1, 2'd2, 32'h1, 0, 0, 0, pc, "R3 ctrl stop");
      cyc(1'b1, 2'd3, 32'h0, 0, 0, 0, pc, "R10 status write");
      idle(2'd3, "R10");
      idle(2'd0, "R10");
      // R7 step
      cyc(1'b1, 2'd0, 32'h4, 0, 0, 0, pc, "R7 step start");
      idle(2'd3, "R7 stepping");
      idle(2'd3, "R7 stepping");
      cyc(1'b0, 2'd3, 32'h0, 0, 0, 1, pc, "R7 retire");
      idle(2'd3, "R7 halted");
      cyc(1'b1, 2'd2, 32'h0, 0, 0, 0, pc, "R4");
      cyc(1'b1, 2'd0, 32'h4, 0, 0, 0, pc, "R7 step while running");
      cyc(1'b0, 2'd3, 32'h0, 0, 0, 1, pc, "R7 still running");
      // R5 break-in
      cyc(1'b0, 2'd3, 32'h0, 1, 0, 0, pc, "R5 disabled");
      idle(2'd3, "R5");
      cyc(1'b1, 2'd1, 32'h3C, 0, 0, 0, pc, "R2");
      cyc(1'b0, 2'd3, 32'h0, 1, 0, 0, pc, "R5 enabled");
      idle(2'd3, "R5");
      // R6 breakpoint
      cyc(1'b1, 2'd0, 32'h1, 0, 0, 0, pc, "R4");
      cyc(1'b0, 2'd3, 32'h0, 0, 1, 0, pc, "R6 disabled");
      cyc(1'b1, 2'd1, 32'hC0, 0, 0, 0, pc, "R2");
      cyc(1'b0, 2'd3, 32'h0, 0, 1, 0, pc, "R6 enabled");
      idle(2'd3, "R6");
      // R8 command pulse
      cyc(1'b1, 2'd0, 32'h8, 0, 0, 0, pc, "R8 cmd");
      idle(2'd0, "R8 single cycle");
      // R9 program counter
      cyc(1'b0, 2'd3, 32'h0, 0, 0, 0, 16'hFFFF, "R9");
      cyc(1'b0, 2'd3, 32'h0, 0, 0, 0, 16'h1234, "R9");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [1:0] a;
         logic [31:0] d;
         bit w;
         a = 2'($urandom % 4);
         w = ($urandom % 3) == 0;
         case (a)
            2'd0: d = 32'($urandom % 16);
            2'd2: d = 32'($urandom % 3);
            default: d = 32'($urandom % 256);
         endcase
         cyc(w, a, d, ($urandom % 8) == 0, ($urandom % 8) == 0,
             ($urandom % 4) == 0, 16'($urandom), "R3 random run");
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule